// File: doc/BRIEF.md
# Gather Address Conflict Resolver

This block takes the element addresses of one gather or scatter vector, up to 128 quadword addresses with one address per element, and packs them into slices that a banked L2 cache can serve in a single access cycle. Each element is bound to a fixed lane, its index modulo 16. The cache splits a line address across 16 banks, using address bits [9:6]. A slice has one slot per lane. It never holds two elements of the same lane or two addresses that fall into the same bank.

Elements arrive one per cycle as an index and an address, and they wait in a pending pool. Whenever the pool is not empty and the output register is free or being consumed, the block scans the pool in ascending element index. It takes every element whose lane and bank are both still unused in the slice being built. The taken elements leave the pool, and the slice is registered at the output. Elements that arrive while a slice is being formed join the pool for the next round. The final input of a vector is flagged. The slice that leaves the pool empty after that flag carries a last marker, which closes the vector.

Top module: `gather_slice_packer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_valid and out_last are 0 and the pool is empty.
- R2: Output slot s only ever carries an element whose index modulo 16 equals s.
- R3: No two valid slots of one slice have equal address bits [9:6] (the bank).
- R4: A slice is formed on a clock edge when the pool is not empty and out_valid is 0 or out_ready is 1. Pending elements are visited in ascending index, and an element is taken exactly when its lane and its bank are both unused by elements already taken for that slice.
- R5: Every element delivered to the block appears in exactly one slice, in the slot of its lane, with its address unchanged.
- R6: An element presented on the same edge that forms a slice is not part of that slice. It is considered from the next formation on.
- R7: While out_valid is 1 and out_ready is 0, all slice outputs hold their values.
- R8: out_last is 1 on exactly the slice after which the pool is empty, provided the last-flagged input was accepted on an earlier edge. It occurs once per vector.
- R9: When all 128 elements share one bank, the vector yields 128 slices of one element each, in ascending index order.
- R10: When the pool is empty and the output is consumed, out_valid goes to 0 and no empty slice is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An element is presented this cycle |
| in_idx | input | IDX_W (7) | Element index, fixes the lane (index modulo 16) |
| in_addr | input | ADDR_W (32) | Quadword address of the element |
| in_last | input | 1 | This element is the final one of the vector |
| out_ready | input | 1 | Consumer accepts the current slice |
| out_valid | output | 1 | A slice is held on the outputs |
| out_last | output | 1 | The held slice closes the vector |
| out_slot_vld | output | LANES (16) | Per-lane slot occupied |
| out_slot_idx | output | LANES x IDX_W | Element index in each slot |
| out_slot_addr | output | LANES x ADDR_W | Address in each slot |

## Verification
The bench keeps a cycle-level model of the pool and checks the greedy packing against it for several address patterns. Distinct banks on distinct lanes must pack in a single pass. Addresses that share one bank must degrade to single-element slices, which separates bank checking from lane checking. Banks tied to the lane, and banks independent of the lane, show whether the two conflict sets are tracked separately. Pseudo-random addresses with permuted arrival orders and irregular out_ready exercise in-flight arrival, stalls with held outputs and the placement of the last marker.

// File: rtl/gsp_pkg.sv
// Package: shared constants and helpers for the gather slice packer.
// Assumes lanes are selected by the low bits of the element index.
package gsp_pkg;
    localparam int DEF_ELEMS    = 128;
    localparam int DEF_LANES    = 16;
    localparam int DEF_ADDR_W   = 32;
    localparam int DEF_BANK_LSB = 6;
    localparam int DEF_BANK_W   = 4;

    // Slot state of a formed slice, one field set per lane.
    typedef enum logic [0:0] {
        SLOT_EMPTY = 1'b0,
        SLOT_BUSY  = 1'b1
    } slot_state_e;
endpackage

// File: rtl/gsp_pool.sv
// Module: pending element pool.
// Holds one pending bit and one address per element index. Elements taken
// by a formed slice are cleared, new arrivals are set on the same edge.
// Assumes an index is not presented again while it is still pending.
module gsp_pool #(
    parameter int N_ELEM = 128,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(N_ELEM)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic [IDX_W-1:0]               in_idx,
    input  logic [ADDR_W-1:0]              in_addr,
    input  logic                           in_last,
    input  logic                           take_en,
    input  logic [N_ELEM-1:0]              take,
    input  logic                           vec_done,
    output logic [N_ELEM-1:0]              pend,
    output logic [N_ELEM-1:0][ADDR_W-1:0]  addr,
    output logic                           all_in
);
    logic [N_ELEM-1:0] arrive;

    // Decode the arriving index into a one-hot set vector.
    always_comb begin
        arrive = '0;
        if (in_valid) arrive[in_idx] = 1'b1;
    end

    // Per-element storage, one pending bit and one address register each.
    for (genvar e = 0; e < N_ELEM; e++) begin : g_elem
        // Pending bit: clear on take, set on arrival.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend[e] <= 1'b0;
            else if (arrive[e])
                pend[e] <= 1'b1;
            else if (take_en && take[e])
                pend[e] <= 1'b0;
        end

        // Address capture on arrival.
        always_ff @(posedge clk) begin
            if (arrive[e]) addr[e] <= in_addr;
        end
    end

    // Tracks that the last-flagged element of the vector has arrived.
    always_ff @(posedge clk) begin
        if (!rst_n)
            all_in <= 1'b0;
        else if (in_valid && in_last)
            all_in <= 1'b1;
        else if (vec_done)
            all_in <= 1'b0;
    end
endmodule

// File: rtl/gsp_select.sv
// Module: greedy conflict-free subset selection.
// Walks pending elements in ascending index and takes each whose lane
// (index modulo LANES) and bank (address field) are still free. Purely
// combinational; the chain is N_ELEM stages deep.
module gsp_select #(
    parameter int N_ELEM   = 128,
    parameter int LANES    = 16,
    parameter int ADDR_W   = 32,
    parameter int BANK_LSB = 6,
    parameter int BANK_W   = 4,
    localparam int IDX_W   = $clog2(N_ELEM),
    localparam int LANE_W  = $clog2(LANES),
    localparam int BANKS   = 1 << BANK_W
) (
    input  logic [N_ELEM-1:0]              pend,
    input  logic [N_ELEM-1:0][ADDR_W-1:0]  addr,
    output logic [N_ELEM-1:0]              take,
    output logic [LANES-1:0]               slot_vld,
    output logic [LANES-1:0][IDX_W-1:0]    slot_idx,
    output logic [LANES-1:0][ADDR_W-1:0]   slot_addr
);
    logic [BANKS-1:0]  bank_used;
    logic [LANES-1:0]  lane_used;
    logic [LANE_W-1:0] ln;
    logic [BANK_W-1:0] bk;

    // Greedy scan in ascending element index.
    always_comb begin
        bank_used = '0;
        lane_used = '0;
        take      = '0;
        slot_vld  = '0;
        slot_idx  = '0;
        slot_addr = '0;
        ln        = '0;
        bk        = '0;
        for (int i = 0; i < N_ELEM; i++) begin
            ln = LANE_W'(i % LANES);
            bk = addr[i][BANK_LSB +: BANK_W];
            if (pend[i] && !lane_used[ln] && !bank_used[bk]) begin
                take[i]       = 1'b1;
                lane_used[ln] = 1'b1;
                bank_used[bk] = 1'b1;
                slot_vld[ln]  = 1'b1;
                slot_idx[ln]  = IDX_W'(i);
                slot_addr[ln] = addr[i];
            end
        end
    end
endmodule

// File: rtl/gsp_slice_reg.sv
// Module: slice output register.
// Loads a newly formed slice, holds it while the consumer stalls and drops
// out_valid once the slice is consumed with nothing new to load.
module gsp_slice_reg #(
    parameter int LANES  = 16,
    parameter int IDX_W  = 7,
    parameter int ADDR_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic                          out_ready,
    input  logic                          nxt_last,
    input  logic [LANES-1:0]              nxt_vld,
    input  logic [LANES-1:0][IDX_W-1:0]   nxt_idx,
    input  logic [LANES-1:0][ADDR_W-1:0]  nxt_addr,
    output logic                          out_valid,
    output logic                          out_last,
    output gsp_pkg::slot_state_e [LANES-1:0] slot_state,
    output logic [LANES-1:0][IDX_W-1:0]   out_idx,
    output logic [LANES-1:0][ADDR_W-1:0]  out_addr
);
    // Valid and last flags of the held slice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_last  <= nxt_last;
        end else if (out_ready) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
        end
    end

    // Per-lane slot payload registers.
    for (genvar s = 0; s < LANES; s++) begin : g_slot
        // Slot capture on load, cleared at reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_state[s] <= gsp_pkg::SLOT_EMPTY;
                out_idx[s]    <= '0;
                out_addr[s]   <= '0;
            end else if (load) begin
                slot_state[s] <= nxt_vld[s] ? gsp_pkg::SLOT_BUSY : gsp_pkg::SLOT_EMPTY;
                out_idx[s]    <= nxt_idx[s];
                out_addr[s]   <= nxt_addr[s];
            end
        end
    end
endmodule

// File: rtl/gather_slice_packer.sv
// Module: gather address conflict resolver, top level.
// Pools element addresses, forms one lane- and bank-conflict-free slice per
// cycle while the output can accept, and marks the slice that empties the
// pool after the last-flagged input. Assumes one vector at a time and that a
// new vector starts only after the last slice of the previous one is formed.
module gather_slice_packer #(
    parameter int N_ELEM   = gsp_pkg::DEF_ELEMS,
    parameter int LANES    = gsp_pkg::DEF_LANES,
    parameter int ADDR_W   = gsp_pkg::DEF_ADDR_W,
    parameter int BANK_LSB = gsp_pkg::DEF_BANK_LSB,
    parameter int BANK_W   = gsp_pkg::DEF_BANK_W,
    localparam int IDX_W   = $clog2(N_ELEM)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [IDX_W-1:0]              in_idx,
    input  logic [ADDR_W-1:0]             in_addr,
    input  logic                          in_last,
    input  logic                          out_ready,
    output logic                          out_valid,
    output logic                          out_last,
    output logic [LANES-1:0]              out_slot_vld,
    output logic [LANES-1:0][IDX_W-1:0]   out_slot_idx,
    output logic [LANES-1:0][ADDR_W-1:0]  out_slot_addr
);
    logic [N_ELEM-1:0]              pend;
    logic [N_ELEM-1:0][ADDR_W-1:0]  addr_q;
    logic                           all_in;
    logic [N_ELEM-1:0]              take;
    logic [LANES-1:0]               sel_vld;
    logic [LANES-1:0][IDX_W-1:0]    sel_idx;
    logic [LANES-1:0][ADDR_W-1:0]   sel_addr;
    logic                           load;
    logic                           slice_last;
    gsp_pkg::slot_state_e [LANES-1:0] slot_state;

    // Formation condition and last-slice detection.
    always_comb begin
        load       = (|pend) && (!out_valid || out_ready);
        slice_last = all_in && ((pend & ~take) == '0);
    end

    gsp_pool #(
        .N_ELEM (N_ELEM),
        .ADDR_W (ADDR_W)
    ) u_pool (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_idx   (in_idx),
        .in_addr  (in_addr),
        .in_last  (in_last),
        .take_en  (load),
        .take     (take),
        .vec_done (load && slice_last),
        .pend     (pend),
        .addr     (addr_q),
        .all_in   (all_in)
    );

    gsp_select #(
        .N_ELEM   (N_ELEM),
        .LANES    (LANES),
        .ADDR_W   (ADDR_W),
        .BANK_LSB (BANK_LSB),
        .BANK_W   (BANK_W)
    ) u_select (
        .pend      (pend),
        .addr      (addr_q),
        .take      (take),
        .slot_vld  (sel_vld),
        .slot_idx  (sel_idx),
        .slot_addr (sel_addr)
    );

    gsp_slice_reg #(
        .LANES  (LANES),
        .IDX_W  (IDX_W),
        .ADDR_W (ADDR_W)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .out_ready  (out_ready),
        .nxt_last   (slice_last),
        .nxt_vld    (sel_vld),
        .nxt_idx    (sel_idx),
        .nxt_addr   (sel_addr),
        .out_valid  (out_valid),
        .out_last   (out_last),
        .slot_state (slot_state),
        .out_idx    (out_slot_idx),
        .out_addr   (out_slot_addr)
    );

    // Flatten slot states into the occupancy vector.
    for (genvar s = 0; s < LANES; s++) begin : g_vld
        assign out_slot_vld[s] = (slot_state[s] == gsp_pkg::SLOT_BUSY);
    end
endmodule

// File: rtl/gather_slice_packer_chk.sv
// Module: property checker for the gather slice packer, bound to the top.
// Observes only top-level ports.
module gather_slice_packer_chk #(
    parameter int N_ELEM   = 128,
    parameter int LANES    = 16,
    parameter int ADDR_W   = 32,
    parameter int BANK_LSB = 6,
    parameter int BANK_W   = 4,
    localparam int IDX_W   = $clog2(N_ELEM),
    localparam int LANE_W  = $clog2(LANES)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          out_ready,
    input logic                          out_valid,
    input logic                          out_last,
    input logic [LANES-1:0]              out_slot_vld,
    input logic [LANES-1:0][IDX_W-1:0]   out_slot_idx,
    input logic [LANES-1:0][ADDR_W-1:0]  out_slot_addr
);
    // R1: the cycle after a reset edge shows no slice
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> !out_valid && !out_last);

    // R7: stalled slice holds its contents
    assert_hold_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_last)
            && $stable(out_slot_vld) && $stable(out_slot_idx) && $stable(out_slot_addr));

    // R10: a presented slice is never empty
    assert_no_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_slot_vld != '0);

    // R8: last marker only accompanies a presented slice
    assert_last_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    for (genvar s = 0; s < LANES; s++) begin : g_lane
        // R2: slot s holds only an element of lane s
        assert_lane_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid && out_slot_vld[s] |-> out_slot_idx[s][LANE_W-1:0] == LANE_W'(s));

        for (genvar t = s + 1; t < LANES; t++) begin : g_pair
            // R3: two occupied slots never share a bank
            assert_bank_unique_R3: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid && out_slot_vld[s] && out_slot_vld[t]
                |-> out_slot_addr[s][BANK_LSB +: BANK_W] != out_slot_addr[t][BANK_LSB +: BANK_W]);
        end
    end
endmodule

bind gather_slice_packer gather_slice_packer_chk #(
    .N_ELEM   (N_ELEM),
    .LANES    (LANES),
    .ADDR_W   (ADDR_W),
    .BANK_LSB (BANK_LSB),
    .BANK_W   (BANK_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .out_ready     (out_ready),
    .out_valid     (out_valid),
    .out_last      (out_last),
    .out_slot_vld  (out_slot_vld),
    .out_slot_idx  (out_slot_idx),
    .out_slot_addr (out_slot_addr)
);

// File: tb/gather_slice_packer_test.sv
// Bench: cycle-level pool model checks every formed slice, stall hold,
// idle behaviour, per-vector coverage and the last marker.
module gather_slice_packer_test;
    localparam int N      = 128;
    localparam int LANES  = 16;
    localparam int ADDR_W = 32;
    localparam int IDX_W  = 7;

    logic                          clk = 1'b0;
    logic                          rst_n = 1'b0;
    logic                          in_valid = 1'b0;
    logic [IDX_W-1:0]              in_idx = '0;
    logic [ADDR_W-1:0]             in_addr = '0;
    logic                          in_last = 1'b0;
    logic                          out_ready = 1'b0;
    logic                          out_valid;
    logic                          out_last;
    logic [LANES-1:0]              out_slot_vld;
    logic [LANES-1:0][IDX_W-1:0]   out_slot_idx;
    logic [LANES-1:0][ADDR_W-1:0]  out_slot_addr;

    gather_slice_packer uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_idx(in_idx),
        .in_addr(in_addr), .in_last(in_last), .out_ready(out_ready),
        .out_valid(out_valid), .out_last(out_last), .out_slot_vld(out_slot_vld),
        .out_slot_idx(out_slot_idx), .out_slot_addr(out_slot_addr)
    );

    always #5 clk = ~clk;

    int nvec = 0;
    int nbad = 0;
    int cyc  = 0;

    logic              mpend [N];
    logic [ADDR_W-1:0] maddr [N];
    logic              mall_in;
    int                seen [N];
    logic              drv [N];
    int                slices;
    int                lasts;
    logic              got_last;

    logic [LANES-1:0]              p_vld;
    logic [LANES-1:0][IDX_W-1:0]   p_idx;
    logic [LANES-1:0][ADDR_W-1:0]  p_addr;
    logic                          p_last;

    task automatic fail_msg(input string req, input string what,
                            input longint act, input longint exp);
        $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    endtask

    // One clock: decide the expected slice, drive, advance, compare.
    task automatic step(input logic v, input logic [IDX_W-1:0] idx,
                        input logic [ADDR_W-1:0] a, input logic lst, input logic rdy);
        logic any, load, e_last, was_valid, bad;
        logic [LANES-1:0] lu, bu, e_vld;
        logic [LANES-1:0][IDX_W-1:0] e_idx;
        logic [LANES-1:0][ADDR_W-1:0] e_addr;
        logic tk [N];
        any = 1'b0;
        for (int i = 0; i < N; i++) begin
            any = any | mpend[i];
            tk[i] = 1'b0;
        end
        was_valid = out_valid;
        load = any && (!was_valid || rdy);
        lu = '0; bu = '0; e_vld = '0; e_idx = '0; e_addr = '0; e_last = 1'b0;
        if (load) begin
            // R4: greedy ascending pick, lane = idx mod 16, bank = addr[9:6]
            for (int i = 0; i < N; i++) begin
                int ln, bk;
                ln = i % LANES;
                bk = int'(maddr[i][9:6]);
                if (mpend[i] && !lu[ln] && !bu[bk]) begin
                    lu[ln] = 1'b1; bu[bk] = 1'b1; tk[i] = 1'b1;
                    e_vld[ln] = 1'b1; e_idx[ln] = IDX_W'(i); e_addr[ln] = maddr[i];
                end
            end
            e_last = mall_in;
            for (int i = 0; i < N; i++) if (mpend[i] && !tk[i]) e_last = 1'b0;
            for (int i = 0; i < N; i++) if (tk[i]) mpend[i] = 1'b0;
            if (e_last) mall_in = 1'b0;
        end
        // R6: arrivals enter the model only after this edge's formation
        if (v) begin
            mpend[idx] = 1'b1; maddr[idx] = a; drv[idx] = 1'b1;
            if (lst) mall_in = 1'b1;
        end
        in_valid = v; in_idx = idx; in_addr = a; in_last = lst; out_ready = rdy;
        @(posedge clk);
        @(negedge clk);
        cyc++;
        in_valid = 1'b0; in_last = 1'b0;
        nvec++;
        bad = 1'b0;
        if (load) begin
            if (!out_valid) begin bad = 1'b1; fail_msg("R4", "out_valid", 0, 1); end
            if (out_last !== e_last) begin
                bad = 1'b1; fail_msg("R8", "out_last", longint'(out_last), longint'(e_last));
            end
            for (int s = 0; s < LANES; s++) begin
                if (out_slot_vld[s] !== e_vld[s] ||
                    (e_vld[s] && (out_slot_idx[s] !== e_idx[s] || out_slot_addr[s] !== e_addr[s]))) begin
                    bad = 1'b1;
                    $display("FAIL R4 R6 slot %0d: actual v%0d i%0d a%0h expected v%0d i%0d a%0h",
                             s, out_slot_vld[s], out_slot_idx[s], out_slot_addr[s],
                             e_vld[s], e_idx[s], e_addr[s]);
                end
                if (out_slot_vld[s]) seen[int'(out_slot_idx[s])]++;
            end
            slices++;
            if (out_last) begin lasts++; got_last = 1'b1; end
        end else if (was_valid && !rdy) begin
            // R7: stalled slice must not change
            if (!out_valid || out_slot_vld !== p_vld || out_slot_idx !== p_idx ||
                out_slot_addr !== p_addr || out_last !== p_last) begin
                bad = 1'b1; fail_msg("R7", "held slice vld", longint'(out_slot_vld), longint'(p_vld));
            end
        end else begin
            // R10: nothing pending, consumed output goes idle
            if (out_valid !== 1'b0) begin
                bad = 1'b1; fail_msg("R10", "out_valid idle", longint'(out_valid), 0);
            end
        end
        if (bad) nbad++;
        p_vld = out_slot_vld; p_idx = out_slot_idx; p_addr = out_slot_addr; p_last = out_last;
    endtask

    function automatic logic [ADDR_W-1:0] addr_of(input int pat, input int idx);
        logic [ADDR_W-1:0] h;
        case (pat)
            0: addr_of = ADDR_W'(idx) << 6;
            1: addr_of = ADDR_W'(idx) << 10;
            2: addr_of = (ADDR_W'(idx % 16) << 6) | (ADDR_W'(idx / 16) << 10);
            3: addr_of = (ADDR_W'((idx / 16) % 16) << 6) | (ADDR_W'(idx) << 12);
            default: begin
                h = ADDR_W'(idx + 7) * 32'h9E3779B1;
                addr_of = (h ^ (h >> 13)) & 32'hFFFF_FFF8;
            end
        endcase
    endfunction

    function automatic logic rdy_of(input int mode, input logic loading, input int c);
        case (mode)
            0: rdy_of = !loading;
            1: rdy_of = 1'b1;
            default: rdy_of = (c % 3) != 0;
        endcase
    endfunction

    // Drive one vector and drain it; check coverage and the marker count.
    task automatic run_vector(input int pat, input int n, input logic perm,
                              input int mode, input int exp_slices);
        int guard;
        logic ok;
        for (int i = 0; i < N; i++) begin seen[i] = 0; drv[i] = 1'b0; end
        slices = 0; lasts = 0; got_last = 1'b0;
        for (int k = 0; k < n; k++) begin
            int idx;
            idx = perm ? (k * 37) % N : k;
            step(1'b1, IDX_W'(idx), addr_of(pat, idx), k == n - 1, rdy_of(mode, 1'b1, cyc));
        end
        guard = 0;
        while (!got_last && guard < 600) begin
            step(1'b0, '0, '0, 1'b0, rdy_of(mode, 1'b0, cyc));
            guard++;
        end
        // Let the final slice be consumed, then observe idleness (R10)
        step(1'b0, '0, '0, 1'b0, 1'b1);
        step(1'b0, '0, '0, 1'b0, 1'b1);
        // R5: each driven element emitted once, nothing else emitted
        nvec++;
        ok = 1'b1;
        for (int i = 0; i < N; i++) begin
            if (seen[i] != (drv[i] ? 1 : 0)) begin
                ok = 1'b0; fail_msg("R5", $sformatf("element %0d count", i), seen[i], drv[i] ? 1 : 0);
            end
        end
        if (!ok) nbad++;
        // R8: one last marker per vector
        nvec++;
        if (lasts != 1) begin nbad++; fail_msg("R8", "last markers", lasts, 1); end
        // R9: slice count where the pattern fixes it
        if (exp_slices > 0) begin
            nvec++;
            if (slices != exp_slices) begin
                nbad++; fail_msg("R9", "slice count", slices, exp_slices);
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin mpend[i] = 1'b0; maddr[i] = '0; end
        mall_in = 1'b0;
        p_vld = '0; p_idx = '0; p_addr = '0; p_last = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state at the ports
        nvec++;
        if (out_valid !== 1'b0 || out_last !== 1'b0) begin
            nbad++; fail_msg("R1", "valid/last in reset", longint'({out_valid, out_last}), 0);
        end
        rst_n = 1'b1;
        // R1: pool empty after reset, so idle cycles yield no slice
        step(1'b0, '0, '0, 1'b0, 1'b1);
        step(1'b0, '0, '0, 1'b0, 1'b0);
        run_vector(0, 16, 1'b0, 0, 0);   // distinct banks and lanes
        run_vector(1, 128, 1'b0, 0, 128); // R9: one shared bank
        run_vector(2, 128, 1'b1, 1, 0);   // bank tied to lane, streaming
        run_vector(3, 128, 1'b0, 2, 0);   // bank independent of lane, stalls
        run_vector(4, 128, 1'b1, 2, 0);   // scattered addresses, stalls
        run_vector(4, 50, 1'b0, 1, 0);    // partial vector
        run_vector(2, 1, 1'b0, 1, 1);     // single element vector
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule